// File: doc/BRIEF.md
# Interrupt Mask and Recognition Controller

This block holds the two interrupt mask flags of a processor core: the non-maskable-line mask (X) and the global maskable mask (I). It decides when the core must begin exception entry. Its inputs are an active-low, level-sensitive non-maskable request line and a vector of maskable requests, each gated by its own local enable. From the core it receives an instruction-boundary strobe, a context-saved strobe, software writes to the two flags, and the flag values restored at return-from-interrupt.

At an instruction boundary the block chooses the highest-priority candidate. One cycle later it raises a single-cycle take pulse and presents the chosen vector index, which it holds until the next entry. No further entry can start until the core reports that the context is saved. On that strobe the block sets I, and it also sets X when the entry was for the non-maskable line. Software can clear X but can never set it again. Only entry for the non-maskable line and the restore path can raise X. All pins are plain control signals. There is no data stream, so no handshake applies.

Top module: `irq_mask_ctrl`

## Requirements
- R1: While and after reset, x_mask=1, i_mask=1, take_irq=0 and vec_idx=0. The non-maskable line is then masked.
- R2: A software write (sw_wr=1) sets X to old X AND sw_x. Clearing works, and a write of 1 while X=0 leaves X at 0.
- R3: A software write loads I from sw_i, 0 or 1, at any time.
- R4: Maskable source n is a candidate only when req[n]=1, req_en[n]=1 and I=0.
- R5: A candidate is accepted only on a cycle with insn_done=1. take_irq goes high for exactly the next cycle, and vec_idx is updated in that same cycle.
- R6: The non-maskable line is active low (nmi_n=0 requests). It is a candidate whenever X=0, whatever I holds. It beats every maskable source and has vector index 0.
- R7: Among maskable candidates the lowest index n wins, with vector index n+1.
- R8: vec_idx holds the value latched at acceptance. Request changes after that do not alter it until the next accepted entry.
- R9: After an accepted entry, no further entry is accepted until a ctx_saved strobe has been seen.
- R10: ctx_saved during an open entry sets I to 1. It also sets X to 1 only when the entry was for the non-maskable line.
- R11: rti_load=1 loads X from rti_x and I from rti_i. This path may raise X from 0 to 1.
- R12: Same-cycle precedence for the flags is ctx_saved (open entry) over rti_load over sw_wr. A ctx_saved with no open entry has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n | input | 1 | Non-maskable request line, active low, level |
| req | input | N_SRC | Maskable request per source |
| req_en | input | N_SRC | Local enable per source |
| insn_done | input | 1 | Instruction-boundary strobe |
| ctx_saved | input | 1 | Context (including flags) stacked strobe |
| sw_wr | input | 1 | Software write of the mask flags |
| sw_x | input | 1 | Software value for X |
| sw_i | input | 1 | Software value for I |
| rti_load | input | 1 | Return-from-interrupt flag restore strobe |
| rti_x | input | 1 | Restored X value |
| rti_i | input | 1 | Restored I value |
| take_irq | output | 1 | Single-cycle begin-exception pulse |
| vec_idx | output | $clog2(N_SRC+1) | Latched vector index |
| x_mask | output | 1 | Current X flag |
| i_mask | output | 1 | Current I flag |

## Verification
The bench targets the sticky X flag. A design that lets software set X again would mask the non-maskable line after release. A design that sets X on maskable entry would block a later non-maskable request. Further cases are a request line held during an open entry, a request that changes after acceptance, and a non-maskable request while I=1. A faulty design would then enter twice, report the wrong vector, or silently drop the non-maskable request. Same-cycle collisions of ctx_saved, rti_load and sw_wr are driven on purpose. A stray ctx_saved with no entry open must leave both flags untouched.

// File: rtl/irq_mask_pkg.sv
package irq_mask_pkg;
  typedef enum logic {
    KIND_MASKABLE = 1'b0,
    KIND_NMI      = 1'b1
  } entry_kind_e;
endpackage

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int N_SRC = 8,
  parameter int VW    = $clog2(N_SRC + 1)
) (
  input  logic             nmi_n,
  input  logic             x_mask,
  input  logic             i_mask,
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] req_en,
  output logic             hit,
  output logic             hit_nmi,
  output logic [VW-1:0]    hit_vec
);
  logic [N_SRC-1:0] pend;
  logic             mask_hit;
  logic [VW-1:0]    mask_vec;

  for (genvar g = 0; g < N_SRC; g++) begin : g_pend
    assign pend[g] = req[g] & req_en[g];
  end

  always_comb begin
    mask_hit = 1'b0;
    mask_vec = '0;
    for (int n = N_SRC - 1; n >= 0; n--) begin
      if (pend[n]) begin
        mask_hit = 1'b1;
        mask_vec = VW'(n + 1);
      end
    end
  end

  assign hit_nmi = ~nmi_n & ~x_mask;
  assign hit     = hit_nmi | (mask_hit & ~i_mask);
  assign hit_vec = hit_nmi ? '0 : mask_vec;
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_mask_pkg::*;
#(
  parameter int VW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          insn_done,
  input  logic          ctx_saved,
  input  logic          hit,
  input  logic          hit_nmi,
  input  logic [VW-1:0] hit_vec,
  output logic          take_q,
  output logic [VW-1:0] vec_q,
  output logic          ctx_fire,
  output entry_kind_e   kind_q
);
  logic busy_q;
  logic accept;

  assign accept   = insn_done & hit & ~busy_q;
  assign ctx_fire = ctx_saved & busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      take_q <= 1'b0;
      vec_q  <= '0;
      kind_q <= KIND_MASKABLE;
    end else begin
      take_q <= accept;
      if (accept) begin
        busy_q <= 1'b1;
        vec_q  <= hit_vec;
        kind_q <= hit_nmi ? KIND_NMI : KIND_MASKABLE;
      end else if (ctx_fire) begin
        busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/irq_mask_regs.sv
module irq_mask_regs
  import irq_mask_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ctx_fire,
  input  entry_kind_e kind,
  input  logic        rti_load,
  input  logic        rti_x,
  input  logic        rti_i,
  input  logic        sw_wr,
  input  logic        sw_x,
  input  logic        sw_i,
  output logic        x_q,
  output logic        i_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_q <= 1'b1;
      i_q <= 1'b1;
    end else if (ctx_fire) begin
      i_q <= 1'b1;
      if (kind == KIND_NMI) x_q <= 1'b1;
    end else if (rti_load) begin
      x_q <= rti_x;
      i_q <= rti_i;
    end else if (sw_wr) begin
      x_q <= x_q & sw_x;
      i_q <= sw_i;
    end
  end
endmodule

// File: rtl/irq_mask_ctrl.sv
module irq_mask_ctrl
  import irq_mask_pkg::*;
#(
  parameter int N_SRC = 8,
  localparam int VW   = $clog2(N_SRC + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_n,
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] req_en,
  input  logic             insn_done,
  input  logic             ctx_saved,
  input  logic             sw_wr,
  input  logic             sw_x,
  input  logic             sw_i,
  input  logic             rti_load,
  input  logic             rti_x,
  input  logic             rti_i,
  output logic             take_irq,
  output logic [VW-1:0]    vec_idx,
  output logic             x_mask,
  output logic             i_mask
);
  logic          hit, hit_nmi, ctx_fire;
  logic [VW-1:0] hit_vec;
  entry_kind_e   kind;

  irq_prio_sel #(.N_SRC(N_SRC), .VW(VW)) u_sel (
    .nmi_n(nmi_n), .x_mask(x_mask), .i_mask(i_mask), .req(req), .req_en(req_en),
    .hit(hit), .hit_nmi(hit_nmi), .hit_vec(hit_vec)
  );

  irq_entry_seq #(.VW(VW)) u_seq (
    .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .ctx_saved(ctx_saved),
    .hit(hit), .hit_nmi(hit_nmi), .hit_vec(hit_vec),
    .take_q(take_irq), .vec_q(vec_idx), .ctx_fire(ctx_fire), .kind_q(kind)
  );

  irq_mask_regs u_regs (
    .clk(clk), .rst_n(rst_n), .ctx_fire(ctx_fire), .kind(kind),
    .rti_load(rti_load), .rti_x(rti_x), .rti_i(rti_i),
    .sw_wr(sw_wr), .sw_x(sw_x), .sw_i(sw_i),
    .x_q(x_mask), .i_q(i_mask)
  );
endmodule

// File: rtl/irq_mask_ctrl_chk.sv
module irq_mask_ctrl_chk #(
  parameter int N_SRC = 8,
  localparam int VW   = $clog2(N_SRC + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          insn_done,
  input logic          ctx_saved,
  input logic          rti_load,
  input logic          take_irq,
  input logic [VW-1:0] vec_idx,
  input logic          x_mask,
  input logic          i_mask
);
  AST_X_RAISE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(x_mask) |-> $past(ctx_saved || rti_load)); // R2
  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |-> $past(insn_done)); // R5
  AST_MASKABLE_NEEDS_I_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && vec_idx != '0) |-> $past(!i_mask)); // R4
  AST_NMI_NEEDS_X_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (take_irq && vec_idx == '0) |-> $past(!x_mask)); // R6
  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !take_irq |-> $stable(vec_idx)); // R8
  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_irq |=> !take_irq); // R9
endmodule

bind irq_mask_ctrl irq_mask_ctrl_chk #(.N_SRC(N_SRC)) u_chk (.*);

// File: tb/irq_mask_ctrl_bench.sv
`timescale 1ns/1ps
module irq_mask_ctrl_bench;
  localparam int N  = 8;
  localparam int VW = $clog2(N + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic nmi_n = 1'b1;
  logic [N-1:0] req = '0, req_en = '0;
  logic insn_done = 0, ctx_saved = 0, sw_wr = 0, sw_x = 0, sw_i = 0;
  logic rti_load = 0, rti_x = 0, rti_i = 0;
  logic take_irq, x_mask, i_mask;
  logic [VW-1:0] vec_idx;

  always #2.5 clk = ~clk;

  irq_mask_ctrl #(.N_SRC(N)) u_irq_mask_ctrl (.*);

  int tests = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  // behavioural reference state
  bit m_x = 1, m_i = 1, m_busy = 0, m_kind_nmi = 0, m_take = 0;
  int m_vec = 0;

  task automatic chk(string r, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      chk("WATCHDOG", "timeout", 1, 0);
      summary();
    end
  end

  task automatic step();
    int c;
    bit nt;
    @(posedge clk);
    c = -1;
    if (!nmi_n && !m_x) c = 0;
    else if (!m_i) begin
      for (int n = N - 1; n >= 0; n--) if (req[n] && req_en[n]) c = n + 1;
    end
    nt = insn_done && !m_busy && (c >= 0);
    if (ctx_saved && m_busy) begin
      m_i = 1; if (m_kind_nmi) m_x = 1; m_busy = 0;
    end else if (rti_load) begin
      m_x = rti_x; m_i = rti_i;
    end else if (sw_wr) begin
      m_x = m_x & sw_x; m_i = sw_i;
    end
    m_take = nt;
    if (nt) begin m_busy = 1; m_vec = c; m_kind_nmi = (c == 0); end
    @(negedge clk);
    chk(cur_req, "take_irq", int'(take_irq), int'(m_take));
    chk(cur_req, "vec_idx", int'(vec_idx), m_vec);
    chk(cur_req, "x_mask", int'(x_mask), int'(m_x));
    chk(cur_req, "i_mask", int'(i_mask), int'(m_i));
  endtask

  task automatic idle();
    insn_done = 0; ctx_saved = 0; sw_wr = 0; rti_load = 0;
  endtask

  task automatic sw(bit x, bit i);
    sw_wr = 1; sw_x = x; sw_i = i; step(); idle();
  endtask

  task automatic rti(bit x, bit i);
    rti_load = 1; rti_x = x; rti_i = i; step(); idle();
  endtask

  task automatic boundary();
    insn_done = 1; step(); idle();
  endtask

  task automatic ctx();
    ctx_saved = 1; step(); idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset x", int'(x_mask), 1);
    chk("R1", "reset i", int'(i_mask), 1);
    chk("R1", "reset take", int'(take_irq), 0);
    rst_n = 1;
    step();
    // R1: pending non-maskable line masked out of reset
    cur_req = "R1"; nmi_n = 0; boundary(); step();
    chk("R1", "nmi masked after reset", int'(take_irq), 0);
    nmi_n = 1;
    // R2: clear X, then an attempt to set it is ignored
    cur_req = "R2"; sw(0, 1);
    chk("R2", "x cleared", int'(x_mask), 0);
    sw(1, 1);
    chk("R2", "x stays clear", int'(x_mask), 0);
    // R3: I either way
    cur_req = "R3"; sw(0, 0); chk("R3", "i cleared", int'(i_mask), 0);
    sw(0, 1); chk("R3", "i set", int'(i_mask), 1);
    // R4: gating by enable and I
    cur_req = "R4"; req = 8'h08; boundary(); step();
    chk("R4", "no take w/o enable", int'(take_irq), 0);
    req_en = 8'h08; boundary();
    chk("R4", "no take with I=1", int'(take_irq), 0);
    sw(0, 0);
    // R5: no strobe, no take
    cur_req = "R5"; step(); step();
    chk("R5", "no take w/o boundary", int'(take_irq), 0);
    boundary();
    chk("R5", "take after boundary", int'(take_irq), 1);
    chk("R7", "vec for src3", int'(vec_idx), 4);
    step(); chk("R5", "take single pulse", int'(take_irq), 0);
    // R9: blocked until ctx
    cur_req = "R9"; boundary(); step();
    chk("R9", "no second entry", int'(take_irq), 0);
    // R8: later request changes do not move vector
    cur_req = "R8"; req = 8'h01; req_en = 8'h01; step();
    chk("R8", "vec held", int'(vec_idx), 4);
    // R10: maskable ctx sets I only
    cur_req = "R10"; ctx();
    chk("R10", "i set on entry", int'(i_mask), 1);
    chk("R10", "x unchanged on maskable", int'(x_mask), 0);
    cur_req = "R11"; rti(0, 0);
    // R7: two sources, lowest wins
    cur_req = "R7"; req = 8'h24; req_en = 8'hFF; boundary();
    chk("R7", "lowest index wins", int'(vec_idx), 3);
    ctx(); rti(0, 1);
    // R6: nmi with I=1, beats maskable
    cur_req = "R6"; nmi_n = 0; boundary();
    chk("R6", "nmi taken with I=1", int'(take_irq), 1);
    chk("R6", "nmi vector", int'(vec_idx), 0);
    nmi_n = 1; req = '0;
    cur_req = "R10"; ctx();
    chk("R10", "x set after nmi ctx", int'(x_mask), 1);
    chk("R10", "i set after nmi ctx", int'(i_mask), 1);
    // R11: restore may raise X
    cur_req = "R11"; rti(0, 0);
    chk("R11", "restore x=0", int'(x_mask), 0);
    rti(1, 0);
    chk("R11", "restore raises x", int'(x_mask), 1);
    chk("R11", "restore i=0", int'(i_mask), 0);
    rti(0, 0);
    // R12: stray ctx ignored; collisions
    cur_req = "R12"; ctx();
    chk("R12", "stray ctx no i", int'(i_mask), 0);
    chk("R12", "stray ctx no x", int'(x_mask), 0);
    rti_load = 1; rti_x = 0; rti_i = 1; sw_wr = 1; sw_x = 0; sw_i = 0; step(); idle();
    chk("R12", "rti beats sw", int'(i_mask), 1);
    sw(0, 0);
    req = 8'h80; req_en = 8'h80; boundary(); req = '0;
    chk("R7", "highest source vector", int'(vec_idx), 8);
    ctx_saved = 1; rti_load = 1; rti_x = 0; rti_i = 0; step(); idle();
    chk("R12", "ctx beats rti", int'(i_mask), 1);
    // R6 with nmi and maskable simultaneously
    cur_req = "R6"; sw(0, 0); req = 8'h02; req_en = 8'h02; nmi_n = 0; boundary();
    chk("R6", "nmi beats maskable", int'(vec_idx), 0);
    nmi_n = 1; req = '0; ctx(); step();
    done = 1;
    summary();
  end
endmodule